// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page mappings and translates each request in the cycle it arrives. A 32-bit virtual address is split into a 20-bit virtual page number and a 12-bit page offset (4 KB pages). The page number is compared against the tag of every entry in parallel. On a match, the physical address is built from the stored physical page number and the untouched offset.

Every entry keeps three status bits: valid, dirty and referenced. A hit marks its entry referenced, and a write hit also marks it dirty. A clear input lets external software or a timer wipe all referenced bits at once. A request that misses raises a miss flag. The requester then fetches the page table entry elsewhere and writes it through the refill port into the slot the block proposes. After that, the access is retried and hits.

Top module: `tlb_fa`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so any request misses and the proposed refill slot is 0.
- R2: When `req_valid` is high, `hit` is high in the same cycle exactly when a valid entry's tag equals `req_vaddr[31:12]`, and `miss` is high exactly when none does; both are low when `req_valid` is low.
- R3: On a hit, `paddr` equals the entry's physical page number in bits [31:12] and `req_vaddr[11:0]` in bits [11:0]; `paddr` is 0 when there is no hit.
- R4: A hit sets the referenced bit of the matching entry at the next clock edge.
- R5: A hit with `req_write` high sets the entry's dirty bit at the next edge. `hit_dirty` reports the entry's stored dirty bit during a hit (0 when there is no hit). A refill loads dirty as 0.
- R6: `victim` is the lowest-numbered invalid entry. If all entries are valid, it is the lowest-numbered entry whose referenced bit is 0. If all referenced bits are 1, it is 0.
- R7: With `fill_valid` high, at the clock edge the slot shown on `victim` is loaded with tag `fill_vpn` and page `fill_ppn`, valid 1, dirty 0 and referenced 0. A retried access to that page hits from the next cycle.
- R8: `clr_ref` clears every referenced bit at the clock edge. An entry hit in the same cycle still ends with its referenced bit set.
- R9: When a refill and a hit name the same slot in one cycle, the refill wins and the slot holds the new mapping with clean status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_write | input | 1 | The request is a store |
| req_vaddr | input | 32 | Virtual address to translate |
| clr_ref | input | 1 | Clear all referenced bits at this edge |
| fill_valid | input | 1 | Write a mapping into the proposed slot |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| hit | output | 1 | Request matched a valid entry |
| miss | output | 1 | Request matched no valid entry |
| paddr | output | 32 | Translated physical address |
| hit_dirty | output | 1 | Stored dirty bit of the matching entry |
| victim | output | 4 | Slot the next refill will write |

## Verification
The assertions take for granted that a refill never loads a page number that some valid entry already holds, so that at most one entry can match a request. The random stimulus draws page numbers from a small pool. It requests a refill only for a number that the bench's own model shows as absent, and it still lets requests, refills and reference clears fall in the same cycle. The small pool, which is larger than the entry count, forces evictions, hits on recently refilled pages and refills that land on an entry hit in the same cycle.

// File: rtl/tlb_pkg.sv
// Package tlb_pkg
// Shared status-bit type and default geometry for the translation buffer.
// Assumes 4 KB pages; the widths here are defaults that the top may override.
package tlb_pkg;
    localparam int DEF_VA_W    = 32;
    localparam int DEF_OFF_W   = 12;
    localparam int DEF_PPN_W   = 20;
    localparam int DEF_ENTRIES = 16;

    // Per-entry status bits kept alongside each mapping.
    typedef struct packed {
        logic valid;
        logic dirty;
        logic refd;
    } tlb_stat_t;
endpackage

// File: rtl/tlb_store.sv
// Module tlb_store
// Holds the tag, physical page and status of every entry and applies the
// per-edge updates: refill, reference/dirty marking on hits, reference clear.
// Assumes upd_idx names a valid entry whenever upd_en is high.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = DEF_PPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_write,
    input  logic             clr_ref,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    output logic [VPN_W-1:0] tag_q  [ENTRIES],
    output logic [PPN_W-1:0] ppn_q  [ENTRIES],
    output tlb_stat_t        stat_q [ENTRIES]
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel_fill;
        logic sel_upd;

        // Decode whether this entry is the refill or the hit target.
        always_comb begin
            sel_fill = fill_en && (fill_idx == IDX_W'(e));
            sel_upd  = upd_en && (upd_idx == IDX_W'(e));
        end

        // Entry state: refill wins, otherwise the clear is followed by the hit marking.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[e] <= '0;
            end else if (sel_fill) begin
                tag_q[e]  <= fill_vpn;
                ppn_q[e]  <= fill_ppn;
                stat_q[e] <= '{valid: 1'b1, dirty: 1'b0, refd: 1'b0};
            end else begin
                if (clr_ref) begin
                    stat_q[e].refd <= 1'b0;
                end
                if (sel_upd) begin
                    stat_q[e].refd <= 1'b1;
                    if (upd_write) begin
                        stat_q[e].dirty <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tlb_match.sv
// Module tlb_match
// One comparator per entry checks the request page number against every
// valid tag at once and encodes the matching slot.
// Assumes at most one entry matches; with more, the lowest index is reported.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] tag_q  [ENTRIES],
    input  tlb_stat_t        stat_q [ENTRIES],
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx
);

    logic [ENTRIES-1:0] eq;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        // Per-entry tag comparator, qualified by the valid bit.
        always_comb eq[e] = stat_q[e].valid && (tag_q[e] == vpn);
    end

    // Encode the matching slot, preferring the lowest index.
    always_comb begin
        hit_any = |eq;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Module tlb_victim
// Proposes the slot for the next refill: first empty slot, else first slot
// not referenced since the last clear, else slot 0.
// Assumes nothing about the inputs beyond the current status bits.
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_stat_t        stat_q [ENTRIES],
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;
    logic             free_any;
    logic             cold_any;

    // Two priority scans, one over invalid slots and one over unreferenced slots.
    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        free_any = 1'b0;
        cold_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!stat_q[i].valid) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
            if (!stat_q[i].refd) begin
                cold_idx = IDX_W'(i);
                cold_any = 1'b1;
            end
        end
    end

    // Pick by preference order.
    always_comb begin
        if (free_any)      victim = free_idx;
        else if (cold_any) victim = cold_idx;
        else               victim = '0;
    end

endmodule

// File: rtl/tlb_fa.sv
// Module tlb_fa
// Fully associative page translation buffer: same-cycle lookup, hardware
// upkeep of referenced/dirty bits, and a refill port into a proposed slot.
// Assumes a refill never carries a page number already held by a valid entry.
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int VA_W    = DEF_VA_W,
    parameter int OFF_W   = DEF_OFF_W,
    parameter int PPN_W   = DEF_PPN_W,
    parameter int ENTRIES = DEF_ENTRIES,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             clr_ref,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    output logic             hit,
    output logic             miss,
    output logic [PA_W-1:0]  paddr,
    output logic             hit_dirty,
    output logic [IDX_W-1:0] victim
);

    logic [VPN_W-1:0] tag_q  [ENTRIES];
    logic [PPN_W-1:0] ppn_q  [ENTRIES];
    tlb_stat_t        stat_q [ENTRIES];
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) match_i (
        .vpn     (req_vaddr[VA_W-1:OFF_W]),
        .tag_q   (tag_q),
        .stat_q  (stat_q),
        .hit_any (hit_any),
        .hit_idx (hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
        .stat_q (stat_q),
        .victim (victim)
    );

    tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (hit),
        .upd_idx   (hit_idx),
        .upd_write (req_write),
        .clr_ref   (clr_ref),
        .fill_en   (fill_valid),
        .fill_idx  (victim),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .tag_q     (tag_q),
        .ppn_q     (ppn_q),
        .stat_q    (stat_q)
    );

    // Request outcome and translated address, all in the request cycle.
    always_comb begin
        hit       = req_valid && hit_any;
        miss      = req_valid && !hit_any;
        paddr     = hit ? {ppn_q[hit_idx], req_vaddr[OFF_W-1:0]} : '0;
        hit_dirty = hit && stat_q[hit_idx].dirty;
    end

endmodule

// File: rtl/tlb_fa_chk.sv
// Module tlb_fa_chk
// Port-level temporal checks for tlb_fa, attached by bind below.
// Assumes refills never duplicate a page number already present.
module tlb_fa_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20,
    parameter int IDX_W = 4,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             clr_ref,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             hit,
    input logic             miss,
    input logic [PA_W-1:0]  paddr,
    input logic             hit_dirty,
    input logic [IDX_W-1:0] victim
);

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!hit && !miss)); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0])); // R3

    AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (paddr == '0) && !hit_dirty); // R3

    AST_EMPTY_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (victim == '0) && !hit); // R1

    AST_REFILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (!(req_valid && req_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) || hit)); // R7

    AST_DIRTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && req_write && !fill_valid) |=>
        (!(req_valid && req_vaddr[VA_W-1:OFF_W] == $past(req_vaddr[VA_W-1:OFF_W])) || hit_dirty)); // R5

    AST_VICTIM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !fill_valid && !clr_ref) |=> $stable(victim)); // R6

endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_vaddr  (req_vaddr),
    .clr_ref    (clr_ref),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .hit        (hit),
    .miss       (miss),
    .paddr      (paddr),
    .hit_dirty  (hit_dirty),
    .victim     (victim)
);

// File: tb/tlb_fa_tb_top.sv
`timescale 1ns/1ps
module tlb_fa_tb_top;
    localparam int N    = 16;
    localparam int POOL = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        clr_ref = 1'b0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        hit;
    logic        miss;
    logic [31:0] paddr;
    logic        hit_dirty;
    logic [3:0]  victim;

    always #2.5 clk = ~clk;

    tlb_fa dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .clr_ref(clr_ref), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .hit(hit), .miss(miss),
        .paddr(paddr), .hit_dirty(hit_dirty), .victim(victim)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural model of the entry set.
    bit          m_v [N];
    bit          m_d [N];
    bit          m_r [N];
    logic [19:0] m_tag [N];
    logic [19:0] m_ppn [N];

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int find(logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int pick_victim();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        for (int i = 0; i < N; i++) if (!m_r[i]) return i;
        return 0;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_r[i] = 0;
        end
    endfunction

    // Compare all outputs against the model, then advance the model for this edge.
    task automatic step();
        int h;
        int vic;
        logic [31:0] exp_pa;
        #1;
        h   = req_valid ? find(req_vaddr[31:12]) : -1;
        vic = pick_victim();
        exp_pa = (h >= 0) ? {m_ppn[h], req_vaddr[11:0]} : 32'h0;
        chk("R2 R7", "hit", hit, h >= 0);
        chk("R2 R1", "miss", miss, req_valid && h < 0);
        chk("R3", "paddr", paddr, exp_pa);
        chk("R5 R9", "hit_dirty", hit_dirty, (h >= 0) ? m_d[h] : 0);
        chk("R6 R4 R8", "victim", victim, vic);
        if (clr_ref) for (int i = 0; i < N; i++) m_r[i] = 0;
        if (h >= 0) begin
            m_r[h] = 1;
            if (req_write) m_d[h] = 1;
        end
        if (fill_valid) begin
            m_v[vic] = 1; m_d[vic] = 0; m_r[vic] = 0;
            m_tag[vic] = fill_vpn; m_ppn[vic] = fill_ppn;
        end
    endtask

    task automatic drive(bit rv, bit wr, logic [19:0] vpn, logic [11:0] off,
                         bit fv, logic [19:0] fvpn, logic [19:0] fppn, bit clr);
        @(negedge clk);
        req_valid = rv; req_write = wr; req_vaddr = {vpn, off};
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; clr_ref = clr;
        step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; req_valid = 0; fill_valid = 0; clr_ref = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    function automatic logic [19:0] pool_vpn(int k);
        return 20'h40000 + 20'(k * 20'h00113);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: empty after reset, every request misses, victim 0.
        drive(1, 0, 20'h00005, 12'h123, 0, 0, 0, 0);
        drive(1, 1, 20'hABCDE, 12'hFFF, 0, 0, 0, 0);
        // R7: refill then retry hits with translated address (R3).
        drive(1, 0, 20'h00005, 12'h123, 1, 20'h00005, 20'h7A001, 0);
        drive(1, 0, 20'h00005, 12'h123, 0, 0, 0, 0);
        // R5: write hit marks dirty; next read reports it.
        drive(1, 1, 20'h00005, 12'h010, 0, 0, 0, 0);
        drive(1, 0, 20'h00005, 12'hABC, 0, 0, 0, 0);
        // Fill the rest so all entries are valid; victim scan moves to references (R6).
        for (int k = 1; k < N; k++)
            drive(0, 0, 0, 0, 1, 20'h00100 + 20'(k), 20'h10000 + 20'(k), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        // R4: touch entry 1, victim shifts past it.
        drive(1, 0, 20'h00101, 12'h0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        // R8: clear together with a hit on entry 2, then plain clear.
        drive(1, 0, 20'h00102, 12'h4, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        // R9: refill into slot 0 while slot 0 is hit with a write.
        drive(1, 1, 20'h00005, 12'h7, 1, 20'h00900, 20'h55555, 0);
        drive(1, 0, 20'h00900, 12'h8, 0, 0, 0, 0);
        drive(1, 0, 20'h00005, 12'h8, 0, 0, 0, 0);
        // Random traffic from a small page pool.
        for (int c = 0; c < 6000; c++) begin
            int k = int'($urandom % POOL);
            int f = int'($urandom % POOL);
            bit fv = ($urandom % 3 == 0) && (find(pool_vpn(f)) < 0);
            bit clr = (c < 3000) ? ($urandom % 40 == 0) : ($urandom % 6 == 0);
            drive($urandom % 4 != 0, $urandom % 3 == 0, pool_vpn(k), 12'($urandom),
                  fv, pool_vpn(f), 20'($urandom), clr);
        end
        // R1 again: mid-run reset empties the buffer.
        do_reset();
        drive(1, 0, pool_vpn(3), 12'h1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule